// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block supplies the slow timing strobes that a sound generator's channel units need. It also raises an optional periodic interrupt. A down-counting divider turns the master clock into a tick near 240 Hz. Each tick advances a looping step sequencer, which runs in one of two modes: four steps or five steps.

Each step can pulse two outputs for one clock cycle:
- a quarter-rate strobe, meant for the envelope and linear-counter units;
- a half-rate strobe, meant for the length-counter and sweep units.

In four-step mode the last step can set an interrupt flag, and the IRQ output carries that flag. Software selects the mode and the interrupt inhibit by writing a control byte. That write also restarts the sequence and reloads the divider. Software clears the flag with an acknowledge pulse, for example on a status read.

Top module: `frameSequencer`

## Requirements
- R1: The divider produces one tick every DIV_COUNT master-clock cycles (default 89490). The first tick after reset falls in the DIV_COUNT-th cycle after reset is released.
- R2: On a control write, bit 7 of the data selects the mode (0 = four-step, 1 = five-step) and bit 6 sets the interrupt inhibit. The other bits have no effect.
- R3: A control write with bit 6 set clears the interrupt flag. A write with bit 6 clear leaves the flag as it was.
- R4: A control write restarts the sequence at step 1 and reloads the divider. The next tick comes DIV_COUNT cycles after the write cycle, and a write wins over a tick that falls in the same cycle.
- R5: A control write that selects five-step mode pulses both strobes in the write cycle itself. The sequence then continues from step 2.
- R6: In four-step mode every tick pulses the quarter-rate strobe. The ticks for steps 2 and 4 also pulse the half-rate strobe.
- R7: In four-step mode, the tick for step 4 sets the interrupt flag when the inhibit is clear. It leaves the flag alone when the inhibit is set.
- R8: In five-step mode:
  - the ticks for steps 1 and 3 pulse both strobes;
  - the ticks for steps 2 and 4 pulse only the quarter-rate strobe;
  - the tick for step 5 pulses neither;
  - the flag is never set.
- R9: After the last step of the active mode, the next tick runs step 1. Strobes appear only in tick or five-step write cycles, and each lasts one cycle.
- R10: An acknowledge pulse clears the flag on the next edge. If a set and a clear fall in the same cycle, the set wins.
- R11: Synchronous reset selects four-step mode with the inhibit clear. It also clears the flag, puts the sequence at step 1 and loads the full divider count.
- R12: The IRQ output equals the interrupt flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write data: bit 7 is the mode, bit 6 is the inhibit |
| irqAck | input | 1 | Clears the interrupt flag |
| quarterStrobe | output | 1 | One-cycle quarter-rate pulse |
| halfStrobe | output | 1 | One-cycle half-rate pulse |
| irqOut | output | 1 | Interrupt request, equal to the flag |

## Verification
The bench builds the block with DIV_COUNT set to 6 instead of 89490. With that setting a full five-step loop takes only 30 cycles, so thousands of ticks fit in a short run. The short period also makes it cheap to place a control write exactly on a tick cycle, to line up an acknowledge with the step-4 flag set, and to walk both modes through many wraps. These cases would be out of reach with the full divider count.

// File: rtl/frameSeqPkg.sv
package frameSeqPkg;

  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] LAST_STEP_FOUR = STEP_W'(3);
  localparam logic [STEP_W-1:0] LAST_STEP_FIVE = STEP_W'(4);
  localparam logic [STEP_W-1:0] IRQ_STEP       = STEP_W'(3);

  typedef struct packed {
    logic              reloadDiv;
    logic              loadStep;
    logic [STEP_W-1:0] stepNext;
  } seqCmd_t;

  function automatic logic quarterOn(input logic fiveStep, input logic [STEP_W-1:0] idx);
    return fiveStep ? (idx != LAST_STEP_FIVE) : 1'b1;
  endfunction

  function automatic logic halfOn(input logic fiveStep, input logic [STEP_W-1:0] idx);
    if (fiveStep) return (idx == STEP_W'(0)) || (idx == STEP_W'(2));
    return (idx == STEP_W'(1)) || (idx == STEP_W'(3));
  endfunction

  function automatic logic [STEP_W-1:0] lastStep(input logic fiveStep);
    return fiveStep ? LAST_STEP_FIVE : LAST_STEP_FOUR;
  endfunction

endpackage

// File: rtl/frameDatapath.sv
module frameDatapath
  import frameSeqPkg::*;
#(
  parameter int unsigned DIV_COUNT = 89490
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCmd_t           cmd,
  output logic              tick,
  output logic [STEP_W-1:0] stepIdx
);

  localparam int DIV_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(DIV_COUNT - 1);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= DIV_MAX;
    end else if (cmd.reloadDiv || divCnt == '0) begin
      divCnt <= DIV_MAX;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
    end else if (cmd.loadStep) begin
      stepIdx <= cmd.stepNext;
    end
  end

  assign tick = (divCnt == '0);

  AST_DIV_RELOAD: assert property (@(posedge clk) disable iff (rst)
    cmd.reloadDiv |=> (divCnt == DIV_MAX)); // R4

  AST_DIV_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!cmd.reloadDiv && divCnt != '0) |=> (divCnt == $past(divCnt) - 1'b1)); // R1

  AST_STEP_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd.loadStep |=> $stable(stepIdx)); // R9

endmodule

// File: rtl/frameControl.sv
module frameControl
  import frameSeqPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MODE_BIT = 7,
  parameter int INH_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic              irqAck,
  input  logic              tick,
  input  logic [STEP_W-1:0] stepIdx,
  output seqCmd_t           cmd,
  output logic              quarterStrobe,
  output logic              halfStrobe,
  output logic              irqOut
);

  logic fiveStep;
  logic inhibit;
  logic irqFlag;
  logic wrMode;
  logic wrInh;
  logic setFlag;
  logic clrFlag;

  assign wrMode = ctrlWrData[MODE_BIT];
  assign wrInh  = ctrlWrData[INH_BIT];

  always_comb begin
    cmd           = '0;
    quarterStrobe = 1'b0;
    halfStrobe    = 1'b0;
    setFlag       = 1'b0;
    if (ctrlWrEn) begin
      cmd.reloadDiv = 1'b1;
      cmd.loadStep  = 1'b1;
      if (wrMode) begin
        quarterStrobe = quarterOn(1'b1, '0);
        halfStrobe    = halfOn(1'b1, '0);
        cmd.stepNext  = STEP_W'(1);
      end else begin
        cmd.stepNext  = '0;
      end
    end else if (tick) begin
      quarterStrobe = quarterOn(fiveStep, stepIdx);
      halfStrobe    = halfOn(fiveStep, stepIdx);
      cmd.loadStep  = 1'b1;
      cmd.stepNext  = (stepIdx == lastStep(fiveStep)) ? '0 : stepIdx + 1'b1;
      setFlag       = !fiveStep && (stepIdx == IRQ_STEP) && !inhibit;
    end
  end

  assign clrFlag = irqAck || (ctrlWrEn && wrInh);

  always_ff @(posedge clk) begin
    if (rst) begin
      fiveStep <= 1'b0;
      inhibit  <= 1'b0;
    end else if (ctrlWrEn) begin
      fiveStep <= wrMode;
      inhibit  <= wrInh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqFlag <= 1'b0;
    end else if (setFlag) begin
      irqFlag <= 1'b1;
    end else if (clrFlag) begin
      irqFlag <= 1'b0;
    end
  end

  assign irqOut = irqFlag;

  AST_HALF_WITH_QUARTER: assert property (@(posedge clk) disable iff (rst)
    halfStrobe |-> quarterStrobe); // R6

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    quarterStrobe |-> (tick || (ctrlWrEn && wrMode))); // R9

  AST_FIVE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (fiveStep && !irqFlag && !ctrlWrEn) |=> !irqFlag); // R8

  AST_INH_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrEn && wrInh) |=> !irqFlag); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irqAck && !setFlag) |=> !irqFlag); // R10

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    stepIdx <= lastStep(fiveStep)); // R9

endmodule

// File: rtl/frameSequencer.sv
module frameSequencer
  import frameSeqPkg::*;
#(
  parameter int unsigned DIV_COUNT = 89490,
  parameter int          DATA_W    = 8,
  parameter int          MODE_BIT  = 7,
  parameter int          INH_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic              irqAck,
  output logic              quarterStrobe,
  output logic              halfStrobe,
  output logic              irqOut
);

  seqCmd_t           seqCmd;
  logic              divTick;
  logic [STEP_W-1:0] curStep;

  frameDatapath #(
    .DIV_COUNT(DIV_COUNT)
  ) uDatapath (
    .clk     (clk),
    .rst     (rst),
    .cmd     (seqCmd),
    .tick    (divTick),
    .stepIdx (curStep)
  );

  frameControl #(
    .DATA_W  (DATA_W),
    .MODE_BIT(MODE_BIT),
    .INH_BIT (INH_BIT)
  ) uControl (
    .clk           (clk),
    .rst           (rst),
    .ctrlWrEn      (ctrlWrEn),
    .ctrlWrData    (ctrlWrData),
    .irqAck        (irqAck),
    .tick          (divTick),
    .stepIdx       (curStep),
    .cmd           (seqCmd),
    .quarterStrobe (quarterStrobe),
    .halfStrobe    (halfStrobe),
    .irqOut        (irqOut)
  );

endmodule

// File: tb/test_frameSequencer.sv
module test_frameSequencer;

  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       ack = 1'b0;
  logic       quarter;
  logic       half;
  logic       irq;

  always #4 clk = ~clk;

  frameSequencer #(.DIV_COUNT(DIV)) i_frameSequencer (
    .clk           (clk),
    .rst           (rst),
    .ctrlWrEn      (wrEn),
    .ctrlWrData    (wrData),
    .irqAck        (ack),
    .quarterStrobe (quarter),
    .halfStrobe    (half),
    .irqOut        (irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int cycleNo = 0;
  int firstTick = -1;

  int mPhase = 0;
  int mStep = 0;
  int mFive = 0;
  int mInh = 0;
  int mFlag = 0;
  string irqTag = "R11";

  int q4[4] = '{1, 1, 1, 1};
  int h4[4] = '{0, 1, 0, 1};
  int q5[5] = '{1, 1, 1, 1, 0};
  int h5[5] = '{1, 0, 1, 0, 0};

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cycle(input bit w, input logic [7:0] d, input bit a);
    int expQ, expH, setF;
    bit tk;
    string tag;
    wrEn = w; wrData = d; ack = a;
    #1;
    cycleNo++;
    tk = (mPhase == DIV - 1);
    expQ = 0; expH = 0; tag = "R9";
    if (w) begin
      if (d[7]) begin expQ = q5[0]; expH = h5[0]; tag = "R5"; end
      else tag = "R4";
    end else if (tk) begin
      if (mFive != 0) begin expQ = q5[mStep]; expH = h5[mStep]; tag = "R1 R8"; end
      else begin expQ = q4[mStep]; expH = h4[mStep]; tag = "R1 R6"; end
    end
    if (quarter && firstTick < 0) firstTick = cycleNo;
    chk(quarter, expQ, tag, "quarterStrobe");
    chk(half, expH, tag, "halfStrobe");
    chk(irq, mFlag, irqTag, "irqOut");
    @(posedge clk);
    setF = 0;
    if (w) begin
      mFive = d[7]; mInh = d[6]; mPhase = 0; mStep = d[7] ? 1 : 0;
    end else if (tk) begin
      setF = (mFive == 0 && mStep == 3 && mInh == 0) ? 1 : 0;
      mStep = (mStep == ((mFive != 0) ? 4 : 3)) ? 0 : mStep + 1;
      mPhase = 0;
    end else begin
      mPhase++;
    end
    if (setF != 0) begin
      mFlag = 1; irqTag = a ? "R10" : "R7";
    end else if (a) begin
      mFlag = 0; irqTag = "R10";
    end else if (w && d[6]) begin
      mFlag = 0; irqTag = "R3";
    end else if (w) begin
      irqTag = "R3";
    end else begin
      irqTag = "R12";
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished at %0t", $time);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(irq, 0, "R11", "irqOut after reset");
    chk(quarter, 0, "R11", "quarterStrobe after reset");
    chk(half, 0, "R11", "halfStrobe after reset");

    idle(40);
    chk(firstTick, DIV, "R1", "first tick cycle");
    chk(irq, 1, "R7", "flag after step 4");

    for (int i = 0; i < 30; i++) cycle(1'b0, 8'h00, 1'b1);
    idle(30);
    cycle(1'b1, 8'h3F, 1'b0);
    chk(irq, 1, "R3", "flag kept after write with inhibit clear");
    idle(3);
    cycle(1'b1, 8'h40, 1'b0);
    idle(30);
    chk(irq, 0, "R2", "inhibited four-step never raises irq");

    cycle(1'b1, 8'h80, 1'b0);
    idle(50);
    chk(irq, 0, "R8", "five-step never raises irq");

    cycle(1'b1, 8'h00, 1'b0);
    idle(DIV - 1);
    cycle(1'b1, 8'h80, 1'b0);
    idle(DIV - 1);
    cycle(1'b1, 8'hC0, 1'b0);
    idle(10);
    cycle(1'b1, 8'h00, 1'b0);
    idle(30);

    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom_range(0, 30) == 0), 8'($urandom_range(0, 255)),
            ($urandom_range(0, 12) == 0));
    end
    finishRun();
  end

endmodule